// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block keeps three interrupt source flags for a network controller: transmit complete, initialization complete and receive. It drives a single interrupt request line from them. Transmit and initialization each have a mask bit. When a mask bit is set, its source cannot raise the request line. The receive flag has no mask. The block also holds a look-ahead enable. When it is set, a receive frame's first-buffer descriptor write-back raises the receive flag, as the last-buffer write-back always does.

The controller's DMA engine gives the block single-cycle event pulses. A receive write-back pulse carries first-buffer and last-buffer qualifiers. Software reaches the block through a small register port. Address 0 is the status register, where writing 1 to a bit clears that bit. Address 1 is the control register, which holds the two mask bits and the look-ahead enable. There are three reset-style inputs. A hard reset and a soft reset leave the masks in different states. A stop request clears the source flags and leaves the control register alone.

Top module: `irq_status_unit`

## Requirements
- R1: `intr` is high whenever the receive flag is set, and otherwise equals (transmit flag AND NOT transmit mask) OR (init flag AND NOT init mask).
- R2: While the transmit mask (control bit 0) is 1, the transmit flag alone never drives `intr` high. While the mask is 0, a set transmit flag drives `intr` high.
- R3: While the init mask (control bit 1) is 1, the init flag alone never drives `intr` high. While the mask is 0, a set init flag drives `intr` high.
- R4: A hard reset leaves the control register reading 0x01, with the transmit mask 1, the init mask 0 and look-ahead 0. It also leaves all flags clear and `intr` low.
- R5: A soft reset leaves the control register reading 0x00 and all flags clear. It takes priority over events and register writes in the same cycle.
- R6: A stop request clears the three source flags and leaves the control register unchanged.
- R7: The status register holds transmit in bit 0, init in bit 1 and receive in bit 2. Writing 1 to a bit clears that bit and writing 0 has no effect. An event in the same cycle as its clear leaves the flag set.
- R8: A receive write-back marked last-buffer sets the receive flag whatever the look-ahead setting. A write-back marked both first and last (a single-buffer frame) sets it once.
- R9: A receive write-back marked first-buffer only sets the receive flag when look-ahead (control bit 2) is 1, and has no effect on the flag otherwise.
- R10: Register bits above bit 2 read as zero at both addresses, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| stop_req | input | 1 | Stop request pulse; clears source flags |
| tx_done_evt | input | 1 | Transmit complete event pulse |
| init_done_evt | input | 1 | Initialization complete event pulse |
| rx_wb_evt | input | 1 | Receive descriptor write-back pulse |
| rx_wb_first | input | 1 | Write-back is for the first buffer of a frame |
| rx_wb_last | input | 1 | Write-back is for the last buffer of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| intr | output | 1 | Interrupt request |

## Verification
Flags and control bits are registered, so an event, a write or a reset pulse shows up one clock edge later. `intr` and `reg_rdata` are combinational from that state and from `reg_addr`, so they are valid in that same following cycle. The bench drives every stimulus just after a falling edge and lets exactly one rising edge pass. It then samples at the next falling edge, changing the read address first and waiting a short delay before each read. Expected values for every mask/flag combination and every look-ahead/first/last combination are computed in the bench from the requirement formulas.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N   = 3;
  localparam int TX_B    = 0;
  localparam int INIT_B  = 1;
  localparam int RX_B    = 2;
  localparam int CTL_N   = 3;
  localparam int MTX_B   = 0;
  localparam int MINIT_B = 1;
  localparam int LA_B    = 2;

  // receive flag raise rule: last buffer always, first buffer only with look-ahead
  function automatic logic rx_raise(input logic la, input logic first, input logic last);
    return last | (la & first);
  endfunction

  // request line: each masked source ANDed with inverted mask, receive unmasked
  function automatic logic intr_of(input logic [SRC_N-1:0] flags,
                                   input logic m_tx, input logic m_init);
    return (flags[TX_B] & ~m_tx) | (flags[INIT_B] & ~m_init) | flags[RX_B];
  endfunction
endpackage

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic clr_all,
  input  logic set_i,
  input  logic w1c_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (clr_all)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (w1c_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             hard_rst,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [CTL_N-1:0] wdata,
  output logic             tx_mask,
  output logic             init_mask,
  output logic             la_en
);
  always_ff @(posedge clk) begin
    if (hard_rst) begin
      tx_mask   <= 1'b1;
      init_mask <= 1'b0;
      la_en     <= 1'b0;
    end else if (soft_rst) begin
      tx_mask   <= 1'b0;
      init_mask <= 1'b0;
      la_en     <= 1'b0;
    end else if (wr_en) begin
      tx_mask   <= wdata[MTX_B];
      init_mask <= wdata[MINIT_B];
      la_en     <= wdata[LA_B];
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          hard_rst,
  input  logic          soft_rst,
  input  logic          stop_req,
  input  logic          tx_done_evt,
  input  logic          init_done_evt,
  input  logic          rx_wb_evt,
  input  logic          rx_wb_first,
  input  logic          rx_wb_last,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          intr
);
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  logic tx_mask, init_mask, la_en;
  logic tx_flag, init_flag, rx_flag;
  logic rx_raise_w, flag_clr_w, stat_wr_w, ctrl_wr_w;
  logic [SRC_N-1:0] src_set, src_w1c, src_flag;

  assign rx_raise_w = rx_wb_evt & rx_raise(la_en, rx_wb_first, rx_wb_last);
  assign flag_clr_w = hard_rst | soft_rst | stop_req;
  assign stat_wr_w  = reg_wr & (reg_addr == ADDR_STAT);
  assign ctrl_wr_w  = reg_wr & (reg_addr == ADDR_CTRL);

  assign src_set[TX_B]   = tx_done_evt;
  assign src_set[INIT_B] = init_done_evt;
  assign src_set[RX_B]   = rx_raise_w;
  assign src_w1c = {SRC_N{stat_wr_w}} & reg_wdata[SRC_N-1:0];

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    irq_flag flag_i (
      .clk    (clk),
      .clr_all(flag_clr_w),
      .set_i  (src_set[i]),
      .w1c_i  (src_w1c[i]),
      .flag_o (src_flag[i])
    );
  end

  assign tx_flag   = src_flag[TX_B];
  assign init_flag = src_flag[INIT_B];
  assign rx_flag   = src_flag[RX_B];

  irq_ctrl_regs ctrl_i (
    .clk      (clk),
    .hard_rst (hard_rst),
    .soft_rst (soft_rst),
    .wr_en    (ctrl_wr_w),
    .wdata    (reg_wdata[CTL_N-1:0]),
    .tx_mask  (tx_mask),
    .init_mask(init_mask),
    .la_en    (la_en)
  );

  assign intr = intr_of(src_flag, tx_mask, init_mask);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STAT) begin
      reg_rdata[SRC_N-1:0] = src_flag;
    end else begin
      reg_rdata[MTX_B]   = tx_mask;
      reg_rdata[MINIT_B] = init_mask;
      reg_rdata[LA_B]    = la_en;
    end
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          hard_rst,
  input logic          soft_rst,
  input logic          stop_req,
  input logic          tx_done_evt,
  input logic          rx_wb_evt,
  input logic          rx_wb_first,
  input logic          rx_wb_last,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          intr,
  input logic          tx_flag,
  input logic          init_flag,
  input logic          rx_flag,
  input logic          tx_mask,
  input logic          init_mask,
  input logic          la_en
);
  // R1
  rx_unmasked_chk: assert property (@(posedge clk) disable iff (hard_rst)
    rx_flag |-> intr);
  // R2
  tx_masked_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (tx_mask && !rx_flag && !(init_flag && !init_mask)) |-> !intr);
  // R2
  tx_unmasked_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (tx_flag && !tx_mask) |-> intr);
  // R3
  init_masked_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (init_mask && !rx_flag && !(tx_flag && !tx_mask)) |-> !intr);
  // R4
  hard_reset_chk: assert property (@(posedge clk) disable iff (hard_rst)
    $past(hard_rst) |-> (tx_mask && !init_mask && !la_en && !intr));
  // R5
  soft_reset_chk: assert property (@(posedge clk) disable iff (hard_rst)
    soft_rst |=> (!tx_mask && !init_mask && !la_en && !intr));
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (stop_req && !soft_rst && !(reg_wr && reg_addr)) |=>
      ($stable(tx_mask) && $stable(init_mask) && $stable(la_en) && !intr));
  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (tx_done_evt && !soft_rst && !stop_req) |=> tx_flag);
  // R8
  rx_last_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (rx_wb_evt && rx_wb_last && !soft_rst && !stop_req) |=> rx_flag);
  // R9
  rx_first_la_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (rx_wb_evt && rx_wb_first && la_en && !soft_rst && !stop_req) |=> rx_flag);
  // R9
  rx_first_nola_chk: assert property (@(posedge clk) disable iff (hard_rst)
    (rx_wb_evt && !rx_wb_last && !la_en && !rx_flag) |=> !rx_flag);
endmodule

bind irq_status_unit irq_status_chk #(.DW(DW)) chk_i (.*);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic hard_rst = 1'b1, soft_rst = 1'b0, stop_req = 1'b0;
  logic tx_done_evt = 1'b0, init_done_evt = 1'b0;
  logic rx_wb_evt = 1'b0, rx_wb_first = 1'b0, rx_wb_last = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic intr;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  irq_status_unit #(.DW(DW)) dut_i (.*);

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic events(input logic t, input logic i, input logic r,
                        input logic f, input logic l);
    tx_done_evt = t; init_done_evt = i; rx_wb_evt = r; rx_wb_first = f; rx_wb_last = l;
    cyc();
    tx_done_evt = 0; init_done_evt = 0; rx_wb_evt = 0; rx_wb_first = 0; rx_wb_last = 0;
  endtask

  function automatic logic exp_intr(input logic [2:0] f, input logic [1:0] m);
    if (f[2]) return 1'b1;
    if (f[0] && !m[0]) return 1'b1;
    return f[1] && !m[1];
  endfunction

  initial begin
    logic [DW-1:0] d;
    @(negedge clk); cyc();
    hard_rst = 1'b0;
    // R4 reset state
    rd(1'b1, d); check("R4 ctrl after hard reset", d, 8'h01);
    rd(1'b0, d); check("R4 status after hard reset", d, 8'h00);
    check("R4 intr after hard reset", {7'b0, intr}, 8'h00);

    // R1 R2 R3 R7: sweep masks x flag patterns
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 8; f++) begin
        wr(1'b1, DW'(m));
        wr(1'b0, 8'h07);
        events(f[0], f[1], f[2], 1'b0, f[2]);
        rd(1'b0, d); check("R7 status pattern", d, DW'(f));
        check("R1 R2 R3 intr", {7'b0, intr}, {7'b0, exp_intr(3'(f), 2'(m))});
      end
    end

    // R7 write-one-to-clear behaviour
    wr(1'b1, 8'h00);
    events(1, 1, 1, 0, 1);
    wr(1'b0, 8'h00); rd(1'b0, d); check("R7 zero write keeps", d, 8'h07);
    wr(1'b0, 8'h01); rd(1'b0, d); check("R7 clear tx only", d, 8'h06);
    events(1, 0, 0, 0, 0);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h07; tx_done_evt = 1'b1;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0; tx_done_evt = 1'b0;
    rd(1'b0, d); check("R7 event beats clear", d, 8'h01);

    // R8 R9 receive raise sweep
    for (int k = 0; k < 8; k++) begin
      logic la, fi, la_st;
      la = k[2]; fi = k[1]; la_st = k[0];
      wr(1'b1, {5'b0, la, 2'b00});
      wr(1'b0, 8'h07);
      events(0, 0, 1, fi, la_st);
      rd(1'b0, d);
      check("R8 R9 rx raise", d, {5'b0, la_st | (la & fi), 2'b00});
    end
    // R8 single-buffer frame sets once and stays clear after clear
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h07);
    events(0, 0, 1, 1, 1);
    rd(1'b0, d); check("R8 single buffer set", d, 8'h04);
    wr(1'b0, 8'h04); cyc();
    rd(1'b0, d); check("R8 single buffer no second raise", d, 8'h00);

    // R10 reserved bits
    wr(1'b1, 8'hFD);
    rd(1'b1, d); check("R10 reserved ctrl bits", d, 8'h05);
    events(1, 1, 1, 0, 1);
    wr(1'b0, 8'hF8);
    rd(1'b0, d); check("R10 reserved status bits", d, 8'h07);

    // R6 stop keeps control, clears flags
    wr(1'b1, 8'h07);
    events(1, 1, 1, 0, 1);
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    rd(1'b1, d); check("R6 stop ctrl kept", d, 8'h07);
    rd(1'b0, d); check("R6 stop flags cleared", d, 8'h00);
    check("R6 stop intr", {7'b0, intr}, 8'h00);

    // R5 soft reset wins over events and write
    events(1, 1, 1, 0, 1);
    soft_rst = 1'b1; tx_done_evt = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h07;
    cyc();
    soft_rst = 1'b0; tx_done_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(1'b1, d); check("R5 soft ctrl", d, 8'h00);
    rd(1'b0, d); check("R5 soft flags", d, 8'h00);
    check("R5 soft intr", {7'b0, intr}, 8'h00);

    // R4 hard reset from cleared masks
    wr(1'b1, 8'h06);
    hard_rst = 1'b1; cyc(); hard_rst = 1'b0;
    rd(1'b1, d); check("R4 hard ctrl again", d, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule